// File: doc/BRIEF.md
# Touch Gesture Command Controller

This block sits behind a touch-decoding front end and turns its touch reports into display commands for a photo viewer. The viewer holds three images. Each image is 800x480, and the three are stacked one above another in a single tall frame buffer. A report is a set of fields held steady by the front end: a first-point coordinate, a touch count and an 8-bit gesture code. A ready strobe qualifies the report. The strobe may be asynchronous to the block clock. The block passes it through a two-flop synchronizer and reacts only to its rising edge.

A small state machine controls the flow and has two states:
- `ST_WAIT` idles until a rising edge of ready. On that edge it captures the report and takes the transition `T_CAPTURE` into `ST_EVAL`.
- `ST_EVAL` lasts one cycle. In it the captured report is classified and its effect is applied. The machine then takes the transition `T_DONE` back to `ST_WAIT`.

The report's effect depends on its class:
- **Navigation gestures** step the active photo index. The index wraps at both ends.
- **Zoom gestures** step a 2-bit zoom level. The level saturates at both ends.
- **Single touch** covers any code outside the defined gesture set. It yields a one-cycle touch pulse carrying the first-point position.

The frame-buffer base address of the active photo is always available at an output. The second-point coordinates of a report play no part in any command, so the block has no ports for them.

Top module: `touch_gesture_ctrl`

## Requirements
- R1: A report is taken only on a rising edge of `rdy_in`. Holding `rdy_in` high for many cycles gives exactly one effect.
- R2: Gesture code 0x14 moves `photo_idx` to the next photo. From the last photo (index 2) it wraps to index 0.
- R3: Gesture code 0x1C moves `photo_idx` to the previous photo. From index 0 it wraps to index 2.
- R4: Gesture code 0x48 raises `zoom_lvl` by one. At 3 it stays at 3.
- R5: Gesture code 0x49 lowers `zoom_lvl` by one. At 0 it stays at 0.
- R6: `frame_base` always equals `photo_idx` times 384000, which is 800*480 pixels.
- R7: A single touch is a code outside the defined gesture set, with a touch count of 1 or 2. It gives a `touch_valid` pulse exactly one cycle wide, with `touch_x`/`touch_y` equal to the report's first-point X/Y. `photo_idx` and `zoom_lvl` stay unchanged.
- R8: The defined gesture set is the even codes 0x10-0x1E, the even codes 0x30-0x3E, and the codes 0x20, 0x22, 0x28, 0x29, 0x40, 0x48 and 0x49. A defined gesture other than 0x14, 0x1C, 0x48 or 0x49 changes nothing and gives no touch pulse. An odd code such as 0x11 counts as a single touch.
- R9: A report with touch count 3, an illegal value, is discarded. It has no effect of any kind.
- R10: A non-gesture report with touch count 0 gives no touch pulse and changes nothing.
- R11: While `rst_n` is low at a clock edge, the block takes `photo_idx` to 0, `zoom_lvl` to 0 and `touch_valid` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rdy_in | input | 1 | Report-ready strobe, may be asynchronous |
| pt1_x | input | 10 | First-point X coordinate |
| pt1_y | input | 9 | First-point Y coordinate |
| touch_cnt | input | 2 | Number of touch points (0, 1 or 2) |
| gesture | input | 8 | Gesture code |
| photo_idx | output | 2 | Active photo index, 0 to 2 |
| frame_base | output | 21 | Pixel base address of the active photo |
| zoom_lvl | output | 2 | Zoom level, 0 (1x) to 3 |
| touch_valid | output | 1 | One-cycle single-touch pulse |
| touch_x | output | 10 | X position of the last single touch |
| touch_y | output | 9 | Y position of the last single touch |

## Verification
The bench builds the block with its default values: three photos of 800x480 and a 2-bit zoom level. With these values, a handful of reports reaches both wrap points of the photo index and both saturation ends of the zoom level. Coordinates at the screen corner (799, 479) exercise the full coordinate widths. Held-high and illegal-count reports probe the edge filter and the discard path.

// File: rtl/tgc_pkg.sv
package tgc_pkg;

    localparam int GEST_W = 8;

    localparam logic [GEST_W-1:0] G_NEXT     = 8'h14;
    localparam logic [GEST_W-1:0] G_PREV     = 8'h1C;
    localparam logic [GEST_W-1:0] G_ZOOM_IN  = 8'h48;
    localparam logic [GEST_W-1:0] G_ZOOM_OUT = 8'h49;

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_NEXT,
        ACT_PREV,
        ACT_ZIN,
        ACT_ZOUT,
        ACT_TOUCH
    } act_e;

    typedef enum logic {
        ST_WAIT,
        ST_EVAL
    } fsm_e;

    // true when the code belongs to the defined gesture set
    function automatic logic is_gesture(input logic [GEST_W-1:0] code);
        logic dir_group;
        dir_group = ((code[7:4] == 4'h1) || (code[7:4] == 4'h3)) && !code[0];
        return dir_group ||
               code == 8'h20 || code == 8'h22 || code == 8'h28 ||
               code == 8'h29 || code == 8'h40 || code == 8'h48 ||
               code == 8'h49;
    endfunction

endpackage

// File: rtl/tgc_ready_edge.sv
module tgc_ready_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], async_in};
            last_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign rise = sync_q[SYNC_STAGES-1] & ~last_q;
endmodule

// File: rtl/tgc_classify.sv
module tgc_classify
    import tgc_pkg::*;
#(
    parameter int CNT_W   = 2,
    parameter int MAX_CNT = 2
) (
    input  logic [GEST_W-1:0] code,
    input  logic [CNT_W-1:0]  cnt,
    output act_e              act
);
    always_comb begin
        act = ACT_NONE;
        if (int'(cnt) <= MAX_CNT) begin
            if (is_gesture(code)) begin
                unique case (code)
                    G_NEXT:     act = ACT_NEXT;
                    G_PREV:     act = ACT_PREV;
                    G_ZOOM_IN:  act = ACT_ZIN;
                    G_ZOOM_OUT: act = ACT_ZOUT;
                    default:    act = ACT_NONE;
                endcase
            end else if (cnt != '0) begin
                act = ACT_TOUCH;
            end
        end
    end
endmodule

// File: rtl/tgc_view_state.sv
module tgc_view_state
    import tgc_pkg::*;
#(
    parameter int NUM_PHOTOS = 3,
    parameter int IMG_W      = 800,
    parameter int IMG_H      = 480,
    parameter int ZOOM_W     = 2,
    localparam int IDX_W     = $clog2(NUM_PHOTOS),
    localparam int FRAME_PIX = IMG_W * IMG_H,
    localparam int ADDR_W    = $clog2(NUM_PHOTOS * FRAME_PIX)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              apply,
    input  act_e              act,
    output logic [IDX_W-1:0]  idx,
    output logic [ZOOM_W-1:0] zoom,
    output logic [ADDR_W-1:0] base
);
    localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(NUM_PHOTOS - 1);
    localparam logic [ZOOM_W-1:0] ZOOM_MAX = '1;
    localparam logic [ADDR_W-1:0] PIX_A    = ADDR_W'(FRAME_PIX);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx  <= '0;
            zoom <= '0;
        end else if (apply) begin
            unique case (act)
                ACT_NEXT: idx  <= (idx == LAST_IDX) ? '0 : idx + 1'b1;
                ACT_PREV: idx  <= (idx == '0) ? LAST_IDX : idx - 1'b1;
                ACT_ZIN:  zoom <= (zoom == ZOOM_MAX) ? zoom : zoom + 1'b1;
                ACT_ZOUT: zoom <= (zoom == '0) ? zoom : zoom - 1'b1;
                default:  ;
            endcase
        end
    end

    assign base = ADDR_W'(idx) * PIX_A;
endmodule

// File: rtl/touch_gesture_ctrl.sv
module touch_gesture_ctrl
    import tgc_pkg::*;
#(
    parameter int X_W        = 10,
    parameter int Y_W        = 9,
    parameter int CNT_W      = 2,
    parameter int NUM_PHOTOS = 3,
    parameter int IMG_W      = 800,
    parameter int IMG_H      = 480,
    parameter int ZOOM_W     = 2,
    localparam int IDX_W     = $clog2(NUM_PHOTOS),
    localparam int ADDR_W    = $clog2(NUM_PHOTOS * IMG_W * IMG_H)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rdy_in,
    input  logic [X_W-1:0]    pt1_x,
    input  logic [Y_W-1:0]    pt1_y,
    input  logic [CNT_W-1:0]  touch_cnt,
    input  logic [GEST_W-1:0] gesture,
    output logic [IDX_W-1:0]  photo_idx,
    output logic [ADDR_W-1:0] frame_base,
    output logic [ZOOM_W-1:0] zoom_lvl,
    output logic              touch_valid,
    output logic [X_W-1:0]    touch_x,
    output logic [Y_W-1:0]    touch_y
);
    fsm_e              state_q, state_d;
    logic              rdy_rise;
    logic [X_W-1:0]    cap_x;
    logic [Y_W-1:0]    cap_y;
    logic [CNT_W-1:0]  cap_cnt;
    logic [GEST_W-1:0] cap_code;
    act_e              act;

    tgc_ready_edge #(.SYNC_STAGES(2)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (rdy_in),
        .rise     (rdy_rise)
    );

    tgc_classify #(.CNT_W(CNT_W), .MAX_CNT(2)) u_cls (
        .code (cap_code),
        .cnt  (cap_cnt),
        .act  (act)
    );

    tgc_view_state #(
        .NUM_PHOTOS (NUM_PHOTOS),
        .IMG_W      (IMG_W),
        .IMG_H      (IMG_H),
        .ZOOM_W     (ZOOM_W)
    ) u_view (
        .clk   (clk),
        .rst_n (rst_n),
        .apply (state_q == ST_EVAL),
        .act   (act),
        .idx   (photo_idx),
        .zoom  (zoom_lvl),
        .base  (frame_base)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_WAIT;
        else        state_q <= state_d;
    end

    // next state: T_CAPTURE on a ready edge, T_DONE after one evaluation cycle
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT: if (rdy_rise) state_d = ST_EVAL;
            ST_EVAL: state_d = ST_WAIT;
        endcase
    end

    // report capture and output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_x       <= '0;
            cap_y       <= '0;
            cap_cnt     <= '0;
            cap_code    <= '0;
            touch_valid <= 1'b0;
            touch_x     <= '0;
            touch_y     <= '0;
        end else begin
            touch_valid <= 1'b0;
            unique case (state_q)
                ST_WAIT: begin
                    if (rdy_rise) begin
                        cap_x    <= pt1_x;
                        cap_y    <= pt1_y;
                        cap_cnt  <= touch_cnt;
                        cap_code <= gesture;
                    end
                end
                ST_EVAL: begin
                    if (act == ACT_TOUCH) begin
                        touch_valid <= 1'b1;
                        touch_x     <= cap_x;
                        touch_y     <= cap_y;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/tgc_checker.sv
module tgc_checker #(
    parameter int NUM_PHOTOS = 3,
    parameter int ZOOM_W     = 2,
    localparam int IDX_W     = $clog2(NUM_PHOTOS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [IDX_W-1:0]  photo_idx,
    input logic [ZOOM_W-1:0] zoom_lvl,
    input logic              touch_valid
);
    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (photo_idx == '0 && zoom_lvl == '0 && !touch_valid)); // R11

    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(photo_idx) < NUM_PHOTOS); // R2

    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (photo_idx != $past(photo_idx)) |->
        (int'(photo_idx) == (int'($past(photo_idx)) + 1) % NUM_PHOTOS ||
         int'(photo_idx) == (int'($past(photo_idx)) + NUM_PHOTOS - 1) % NUM_PHOTOS)); // R3

    AST_ZOOM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (zoom_lvl != $past(zoom_lvl)) |->
        (int'(zoom_lvl) == int'($past(zoom_lvl)) + 1 ||
         int'(zoom_lvl) + 1 == int'($past(zoom_lvl)))); // R4

    AST_TOUCH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        touch_valid |=> !touch_valid); // R7

    AST_TOUCH_KEEPS_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
        touch_valid |-> ($stable(photo_idx) && $stable(zoom_lvl))); // R7
endmodule

bind touch_gesture_ctrl tgc_checker #(
    .NUM_PHOTOS (NUM_PHOTOS),
    .ZOOM_W     (ZOOM_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .photo_idx   (photo_idx),
    .zoom_lvl    (zoom_lvl),
    .touch_valid (touch_valid)
);

// File: tb/sim_touch_gesture_ctrl.sv
`timescale 1ns/1ps
module sim_touch_gesture_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rdy_in = 1'b0;
    logic [9:0]  pt1_x = '0;
    logic [8:0]  pt1_y = '0;
    logic [1:0]  touch_cnt = '0;
    logic [7:0]  gesture = '0;
    logic [1:0]  photo_idx;
    logic [20:0] frame_base;
    logic [1:0]  zoom_lvl;
    logic        touch_valid;
    logic [9:0]  touch_x;
    logic [8:0]  touch_y;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    int seen_x = 0;
    int seen_y = 0;
    bit done = 1'b0;
    int exp_idx = 0;
    int exp_zoom = 0;

    always #2.5 clk = ~clk;

    touch_gesture_ctrl u0 (
        .clk (clk), .rst_n (rst_n), .rdy_in (rdy_in),
        .pt1_x (pt1_x), .pt1_y (pt1_y), .touch_cnt (touch_cnt),
        .gesture (gesture), .photo_idx (photo_idx), .frame_base (frame_base),
        .zoom_lvl (zoom_lvl), .touch_valid (touch_valid),
        .touch_x (touch_x), .touch_y (touch_y)
    );

    always @(negedge clk) begin
        if (touch_valid) begin
            pulses = pulses + 1;
            seen_x = int'(touch_x);
            seen_y = int'(touch_y);
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] g, input logic [1:0] c,
                        input int x, input int y, input int hold);
        @(negedge clk);
        gesture   = g;
        touch_cnt = c;
        pt1_x     = 10'(x);
        pt1_y     = 9'(y);
        rdy_in    = 1'b1;
        repeat (hold) @(negedge clk);
        rdy_in = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic view_check(input string req);
        chk(req, int'(photo_idx), exp_idx);
        chk(req, int'(zoom_lvl), exp_zoom);
        chk({req, " base"}, int'(frame_base), exp_idx * 384000); // R6
    endtask

    task automatic t_reset();
        chk("R11 idx", int'(photo_idx), 0);
        chk("R11 zoom", int'(zoom_lvl), 0);
        chk("R11 touch", int'(touch_valid), 0);
        chk("R6 base", int'(frame_base), 0);
    endtask

    task automatic t_next();
        for (int i = 0; i < 3; i++) begin
            send(8'h14, 2'd1, 0, 0, 6);
            exp_idx = (exp_idx + 1) % 3;
            view_check("R2 next");
        end
    endtask

    task automatic t_prev();
        send(8'h1C, 2'd1, 0, 0, 6);
        exp_idx = 2;
        view_check("R3 prev wrap");
        send(8'h1C, 2'd1, 0, 0, 6);
        exp_idx = 1;
        view_check("R3 prev");
    endtask

    task automatic t_zoom();
        for (int i = 0; i < 4; i++) begin
            send(8'h48, 2'd2, 0, 0, 6);
            if (exp_zoom < 3) exp_zoom++;
            view_check("R4 zoom in");
        end
        for (int i = 0; i < 4; i++) begin
            send(8'h49, 2'd2, 0, 0, 6);
            if (exp_zoom > 0) exp_zoom--;
            view_check("R5 zoom out");
        end
    endtask

    task automatic t_touch();
        int p0;
        p0 = pulses;
        send(8'h00, 2'd1, 799, 479, 6);
        chk("R7 pulse", pulses - p0, 1);
        chk("R7 x", seen_x, 799);
        chk("R7 y", seen_y, 479);
        view_check("R7 view");
        p0 = pulses;
        send(8'h11, 2'd2, 5, 300, 6);
        chk("R8 odd code touch", pulses - p0, 1);
        chk("R8 x", seen_x, 5);
        chk("R8 y", seen_y, 300);
    endtask

    task automatic t_other_gesture();
        int p0;
        p0 = pulses;
        send(8'h20, 2'd1, 1, 1, 6);
        send(8'h3E, 2'd2, 1, 1, 6);
        send(8'h29, 2'd1, 1, 1, 6);
        send(8'h10, 2'd1, 1, 1, 6);
        chk("R8 no pulse", pulses - p0, 0);
        view_check("R8 view");
    endtask

    task automatic t_bad_count();
        int p0;
        p0 = pulses;
        send(8'h14, 2'd3, 0, 0, 6);
        send(8'h48, 2'd3, 0, 0, 6);
        send(8'h00, 2'd3, 9, 9, 6);
        chk("R9 no pulse", pulses - p0, 0);
        view_check("R9 view");
    endtask

    task automatic t_zero_count();
        int p0;
        p0 = pulses;
        send(8'h05, 2'd0, 9, 9, 6);
        chk("R10 no pulse", pulses - p0, 0);
        view_check("R10 view");
    endtask

    task automatic t_held();
        int p0;
        send(8'h14, 2'd1, 0, 0, 40);
        exp_idx = (exp_idx + 1) % 3;
        view_check("R1 held next");
        p0 = pulses;
        send(8'h02, 2'd1, 7, 8, 40);
        chk("R1 held touch", pulses - p0, 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_next();
        t_prev();
        t_zoom();
        t_touch();
        t_other_gesture();
        t_bad_count();
        t_zero_count();
        t_held();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule